// File: doc/BRIEF.md
# Serial Memory Slave with Pause Control

This block is the serial front end of a 256-byte memory model. It serves a four-wire serial bus made up of a clock, a data input, a data output and an active-low select. A separate active-low pause input lets the host halt a transfer partway through and later carry on from the same bit. All pins are oversampled by a fast system clock, so every action happens on a system clock edge. The serial clock is only observed through its sampled edges.

Each command starts with an 8-bit opcode. The block decodes it and, where needed, an 8-bit address. It then streams memory or status bytes out, or passes incoming bytes to an internal write stage. That stage stores them in a register-file array and then reports itself busy for a programmable number of cycles. The serial output comes as a data bit plus an output enable, so that the chip's pad logic can build the tristate.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the output enable is low and the status byte reads 0x00.
- R2: If the select is already low when reset ends, that select is ignored: no bit is captured and the output stays disabled. Commands are accepted only after the select has gone high and then low again.
- R3: Input bits are captured on rising serial clock edges, MSB first. The opcode comes first, then one address byte.
- R4: The output bit changes only after a falling serial clock edge, MSB first. The output enable is low whenever the select is high.
- R5: Raising the select discards a partly received byte or command. The next select starts again with a fresh opcode.
- R6: Opcode 0x03 returns the byte at the given address. Further bytes follow at incrementing addresses, and the address wraps from 0xFF to 0x00.
- R7: Opcode 0x06 sets the write enable latch (status bit 1) and opcode 0x04 clears it. Opcode 0x02 with the latch set stores each following byte at consecutive addresses. With the latch clear, opcode 0x02 is ignored.
- R8: When the select rises after a command that stored data, the write stage turns busy (status bit 0 = 1) for BUSY_CYCLES cycles and the latch is cleared.
- R9: While busy, every opcode other than 0x05 is ignored.
- R10: Opcode 0x05 returns the status byte {user bits 7:2, latch, busy} again and again until the select rises. Opcode 0x01 with the latch set writes the next byte's bits 7:2 into the user bits.
- R11: An unknown opcode makes the block ignore the rest of that select.
- R12: The pause input going low while the serial clock is low enters pause, and going high while the clock is low leaves it. During pause, clock and data changes are ignored, the bit position is kept, and the output enable is low.
- R13: A pause input change while the serial clock is high takes effect only once the clock is next low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| sckPin | input | 1 | Serial clock |
| siPin | input | 1 | Serial data in |
| csNPin | input | 1 | Active-low select |
| holdNPin | input | 1 | Active-low pause |
| soData | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for the serial data out pad |

## Verification
A wrong bit counter or command state shows up within the same select. The read data comes out shifted or from the wrong address, or a store lands somewhere a later read can see it. A wrong write latch or busy flag appears in the next status read, and in stores that are either lost or accepted when they should not be. Pause faults show on the output enable within one serial clock phase, and in misaligned bytes once the transfer resumes.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_READ, ST_WRITE, ST_STAT, ST_WRSR, ST_SKIP
  } stateT;

  typedef struct packed {
    logic rxShift;
    logic addrLoad;
    logic readLoad;
    logic statLoad;
    logic txShift;
    logic memWrite;
    logic setWel;
    logic clrWel;
    logic statWrite;
    logic startBusy;
  } strobeT;
endpackage

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckPin,
  input  logic              siPin,
  input  logic              csNPin,
  input  logic              holdNPin,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              busy,
  input  logic              wel,
  output strobeT            strb,
  output logic              siBit,
  output logic              soOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic sckQ, sckPrev, siQ, csQ, holdNQ;
  logic holdActive, armed, cmdWrite, pendingWrite;
  logic [CNT_W-1:0] bitCnt;
  stateT state, nextState;
  logic active, sckRise, sckFall, byteEnd;

  assign active  = armed && !csQ && !holdActive;
  assign sckRise = active && sckQ && !sckPrev;
  assign sckFall = active && !sckQ && sckPrev;
  assign byteEnd = sckRise && (bitCnt == LAST_BIT);
  assign siBit   = siQ;
  assign soOe    = armed && !csQ && !holdActive;

  always_comb begin
    strb = '0;
    nextState = state;
    strb.startBusy = csQ && pendingWrite;
    strb.clrWel    = csQ && pendingWrite;
    strb.rxShift   = sckRise;
    strb.txShift   = sckFall && (state == ST_READ || state == ST_STAT);
    if (byteEnd) begin
      case (state)
        ST_OPC: begin
          nextState = ST_SKIP;
          if (rxByte == OP_RDSR) begin
            strb.statLoad = 1'b1;
            nextState = ST_STAT;
          end else if (!busy) begin
            case (rxByte)
              OP_READ:  nextState = ST_ADDR;
              OP_WRITE: nextState = wel ? ST_ADDR : ST_SKIP;
              OP_WREN:  strb.setWel = 1'b1;
              OP_WRDI:  strb.clrWel = 1'b1;
              OP_WRSR:  nextState = wel ? ST_WRSR : ST_SKIP;
              default:  nextState = ST_SKIP;
            endcase
          end
        end
        ST_ADDR: begin
          strb.addrLoad = 1'b1;
          strb.readLoad = !cmdWrite;
          nextState = cmdWrite ? ST_WRITE : ST_READ;
        end
        ST_READ:  strb.readLoad = 1'b1;
        ST_WRITE: strb.memWrite = 1'b1;
        ST_STAT:  strb.statLoad = 1'b1;
        ST_WRSR: begin
          strb.statWrite = 1'b1;
          nextState = ST_SKIP;
        end
        default: nextState = ST_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      sckPrev <= 1'b0;
      siQ <= 1'b0;
      csQ <= 1'b0;
      holdNQ <= 1'b1;
      holdActive <= 1'b0;
      armed <= 1'b0;
      cmdWrite <= 1'b0;
      pendingWrite <= 1'b0;
      bitCnt <= '0;
      state <= ST_OPC;
    end else begin
      sckQ <= sckPin;
      sckPrev <= sckQ;
      siQ <= siPin;
      csQ <= csNPin;
      holdNQ <= holdNPin;
      if (csQ) begin
        armed <= 1'b1;
        holdActive <= 1'b0;
        pendingWrite <= 1'b0;
        bitCnt <= '0;
        state <= ST_OPC;
      end else begin
        if (!sckQ) holdActive <= !holdNQ;
        if (sckRise) bitCnt <= bitCnt + 1'b1;
        if (strb.memWrite || strb.statWrite) pendingWrite <= 1'b1;
        if (byteEnd && state == ST_OPC) cmdWrite <= (rxByte == OP_WRITE);
        state <= nextState;
      end
    end
  end

  assert_unarmed_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!strb.rxShift && !soOe));
  assert_busy_blocks_wel_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setWel || strb.memWrite || strb.statWrite) |-> !busy);
  assert_hold_keeps_bit_R12: assert property (@(posedge clk) disable iff (!rstN)
    (holdActive && !csQ) |=> $stable(bitCnt));
endmodule

// File: rtl/spi_mem_data.sv
module spi_mem_data
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BUSY_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              siBit,
  output logic [DATA_W-1:0] rxByte,
  output logic              soBit,
  output logic              busy,
  output logic              wel
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rxShift, txReg, status;
  logic [DATA_W-3:0] userBits;
  logic [ADDR_W-1:0] addr, readAddr;
  logic [BCNT_W-1:0] busyCnt;

  assign rxByte   = {rxShift[DATA_W-2:0], siBit};
  assign busy     = (busyCnt != '0);
  assign status   = {userBits, wel, busy};
  assign readAddr = strb.addrLoad ? rxByte[ADDR_W-1:0] : addr + ADDR_ONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rxShift <= '0;
      txReg <= '0;
      soBit <= 1'b0;
      addr <= '0;
      wel <= 1'b0;
      userBits <= '0;
      busyCnt <= '0;
    end else begin
      if (strb.rxShift) rxShift <= rxByte;
      if (strb.addrLoad) addr <= rxByte[ADDR_W-1:0];
      else if (strb.readLoad || strb.memWrite) addr <= addr + ADDR_ONE;
      if (strb.readLoad) txReg <= mem[readAddr];
      else if (strb.statLoad) txReg <= status;
      else if (strb.txShift) begin
        soBit <= txReg[DATA_W-1];
        txReg <= {txReg[DATA_W-2:0], 1'b0};
      end
      if (strb.memWrite) mem[addr] <= rxByte;
      if (strb.statWrite) userBits <= rxByte[DATA_W-1:2];
      if (strb.clrWel) wel <= 1'b0;
      else if (strb.setWel) wel <= 1'b1;
      if (strb.startBusy) busyCnt <= BCNT_W'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
    end
  end

  assert_write_needs_wel_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWrite |-> wel);
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.startBusy));
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BUSY_CYCLES = 4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckPin,
  input  logic siPin,
  input  logic csNPin,
  input  logic holdNPin,
  output logic soData,
  output logic soOe
);
  strobeT strb;
  logic siBit, busy, wel;
  logic [DATA_W-1:0] rxByte;

  spi_mem_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .siPin(siPin),
    .csNPin(csNPin), .holdNPin(holdNPin), .rxByte(rxByte),
    .busy(busy), .wel(wel), .strb(strb), .siBit(siBit), .soOe(soOe)
  );

  spi_mem_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .siBit(siBit),
    .rxByte(rxByte), .soBit(soData), .busy(busy), .wel(wel)
  );

  assert_so_after_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(soData) |-> !$past(sckPin, 2));
endmodule

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;
  localparam int HALF = 8;
  localparam int NVEC = 5;
  localparam logic [15:0] VEC [NVEC] = '{16'h103C, 16'h11A5, 16'h7F81, 16'h80FF, 16'h4269};

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, si = 1'b0, csN = 1'b0, holdN = 1'b1;
  logic soData, soOe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_mem_slave #(.BUSY_CYCLES(1500)) u_spi_mem_slave (
    .clk(clk), .rstN(rstN), .sckPin(sck), .siPin(si), .csNPin(csN),
    .holdNPin(holdN), .soData(soData), .soOe(soOe)
  );

  task automatic waitHalf(); repeat (HALF) @(negedge clk); endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xferBit(input logic b, output logic r);
    si = b; waitHalf(); r = soData; sck = 1'b1; waitHalf(); sck = 1'b0;
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 0; i--) begin xferBit(tx[i], r); rx[i] = r; end
  endtask

  task automatic sel(); csN = 1'b0; waitHalf(); endtask
  task automatic desel(); waitHalf(); csN = 1'b1; repeat (2 * HALF) @(negedge clk); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d; sel(); xferByte(op, d); desel();
  endtask

  task automatic rdStatus(output logic [7:0] s);
    logic [7:0] d; sel(); xferByte(8'h05, d); xferByte(8'h00, s); desel();
  endtask

  task automatic wrByte(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] d; sel(); xferByte(8'h02, d); xferByte(a, d); xferByte(v, d); desel();
  endtask

  task automatic rdByte(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] d; sel(); xferByte(8'h03, d); xferByte(a, d); xferByte(8'h00, v); desel();
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int k = 0; k < 50; k++) begin rdStatus(s); if (!s[0]) break; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, v, v2, d;
    logic r;
    repeat (5) @(negedge clk);
    check("R1 oe in reset", {7'd0, soOe}, 8'h00);
    rstN = 1'b1;
    // R2: select held low across reset is ignored
    xferByte(8'h05, d);
    check("R2 unarmed oe", {7'd0, soOe}, 8'h00);
    xferByte(8'h00, d);
    check("R2 unarmed oe", {7'd0, soOe}, 8'h00);
    desel();
    check("R4 oe deselected", {7'd0, soOe}, 8'h00);
    rdStatus(s); check("R1 status after reset", s, 8'h00);

    // table walk: R3 R6 R7 R8
    for (int n = 0; n < NVEC; n++) begin
      cmd1(8'h06);
      wrByte(VEC[n][15:8], VEC[n][7:0]);
      rdStatus(s); check("R8 busy after write", s, 8'h01);
      waitIdle();
      rdByte(VEC[n][15:8], v); check("R3 R6 readback", v, VEC[n][7:0]);
    end

    // R7 latch set and clear
    cmd1(8'h06); rdStatus(s); check("R7 wren", s, 8'h02);
    cmd1(8'h04); rdStatus(s); check("R7 wrdi", s, 8'h00);
    wrByte(8'h10, 8'hEE); rdByte(8'h10, v); check("R7 write without latch", v, 8'h3C);

    // R6 R7 multi-byte store with address wrap
    cmd1(8'h06);
    sel(); xferByte(8'h02, d); xferByte(8'hFF, d); xferByte(8'h5A, d); xferByte(8'hC3, d); desel();
    waitIdle();
    sel(); xferByte(8'h03, d); xferByte(8'hFF, d);
    xferByte(8'h00, v); check("R6 read FF", v, 8'h5A);
    xferByte(8'h00, v); check("R6 wrap to 00", v, 8'hC3);
    xferByte(8'h00, v); check("R6 read 01", v, 8'h00);
    desel();

    // R9 commands ignored while busy
    cmd1(8'h06); wrByte(8'h20, 8'h77);
    cmd1(8'h06); rdStatus(s); check("R9 wren ignored while busy", s, 8'h01);
    waitIdle(); rdStatus(s); check("R8 latch cleared", s, 8'h00);

    // R11 unknown opcode
    cmd1(8'h06);
    sel(); xferByte(8'hAB, d); xferByte(8'h20, d); xferByte(8'h11, d); desel();
    rdByte(8'h20, v); check("R11 unknown opcode", v, 8'h77);
    cmd1(8'h04);

    // R5 partial command discarded
    sel(); for (int i = 7; i >= 1; i--) xferBit(VEC[0][i] & 1'b0 | (8'h06 >> i) & 1'b1, r); desel();
    rdStatus(s); check("R5 partial discarded", s, 8'h00);

    // R10 status repeat and user bits
    sel(); xferByte(8'h05, d); xferByte(8'h00, v); xferByte(8'h00, v2); desel();
    check("R10 status first", v, 8'h00); check("R10 status repeat", v2, 8'h00);
    cmd1(8'h06);
    sel(); xferByte(8'h01, d); xferByte(8'hA9, d); desel();
    rdStatus(s); check("R10 R8 status write busy", s, 8'hA9);
    waitIdle(); rdStatus(s); check("R10 user bits", s, 8'hA8);

    // R12 pause with clock low
    sel(); xferByte(8'h03, d); xferByte(8'h10, d);
    for (int i = 7; i >= 5; i--) begin xferBit(1'b0, r); v[i] = r; end
    holdN = 1'b0; waitHalf();
    check("R12 oe off in pause", {7'd0, soOe}, 8'h00);
    for (int k = 0; k < 2; k++) begin si = 1'b1; sck = 1'b1; waitHalf(); sck = 1'b0; waitHalf(); end
    holdN = 1'b1; waitHalf();
    check("R12 oe back", {7'd0, soOe}, 8'h01);
    for (int i = 4; i >= 0; i--) begin xferBit(1'b0, r); v[i] = r; end
    check("R12 byte across pause", v, 8'h3C);
    xferByte(8'h00, v); check("R12 next byte aligned", v, 8'hA5);
    desel();

    // R13 pause request while clock high
    sel(); xferByte(8'h03, d); xferByte(8'h11, d);
    xferBit(1'b0, r); v[7] = r;
    si = 1'b0; waitHalf(); v[6] = soData; sck = 1'b1;
    repeat (2) @(negedge clk); holdN = 1'b0; waitHalf();
    check("R13 no pause while clock high", {7'd0, soOe}, 8'h01);
    sck = 1'b0; waitHalf();
    check("R13 pause once clock low", {7'd0, soOe}, 8'h00);
    holdN = 1'b1; waitHalf();
    for (int i = 5; i >= 0; i--) begin xferBit(1'b0, r); v[i] = r; end
    check("R13 byte across pause", v, 8'hA5);
    desel();
    check("R4 oe after deselect", {7'd0, soOe}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule